// File: doc/BRIEF.md
# Memory bit-field operation unit

This unit runs one bit-field operation against a byte-addressed, big-endian memory. A request gives a base byte address, a signed bit offset, an encoded length and a 32-bit operand value. The first step normalizes the offset into a byte address and a bit position from 0 to 7. The unit then reads every byte the field covers, which is one to five bytes. It finishes with one of seven operations: signed extract, unsigned extract, insert, invert, clear, set or find-first-one.

The four writing operations rebuild the covered bytes and write them back. Bits outside the field keep their old values. The unit returns a 32-bit result and the top bit of the field for a negative flag. A one-cycle `done` pulse marks the point where both are valid. Memory traffic is one byte per transfer. The unit holds `memReq` until `memAck` arrives and drives the direction with `memWe`. While `busy` is high, any new request is ignored.

Top module: `bfmem_unit`

## Requirements
- R1: The 5-bit length field is normalized to ((len - 1) AND 31) + 1, so an encoded 0 selects a 32-bit field.
- R2: The first byte address is base + floor(offset / 8) and the starting bit position is offset AND 7. Bit position 0 is the most significant bit (bit 7) of a byte. A negative offset therefore reaches into lower addresses.
- R3: The unit reads exactly ((offset AND 7) + length - 1) / 8 + 1 bytes (1 to 5). The reads go in ascending address order and start at the first byte address.
- R4: Operation code 0 (signed extract) returns the field sign-extended to 32 bits. The flag `flagN` is the field's top bit.
- R5: Operation code 1 (unsigned extract) returns the field zero-extended. The flag `flagN` is the field's top bit.
- R6: Operation code 2 (insert) stores the low `length` bits of `reqValue` into the field. It returns those bits left-justified in the 32-bit result. The flag `flagN` is the top inserted bit.
- R7: Operation codes 3, 4 and 5 store the field inverted, all zeros or all ones respectively. Each returns the old field left-justified, with its top bit on `flagN`.
- R8: Operation code 6 (find-first-one) returns offset + k. Here k is the index, counted from the field's top bit, of the first 1 in the field. If the field is all zero, k is the length. The flag `flagN` is the field's top bit.
- R9: The writing operations (codes 2 to 5) write back the same bytes they read, in the same ascending order, and change no bit outside the field. Codes 0, 1 and 6 make no write.
- R10: Once `memReq` is raised, it stays high with an unchanged address and direction until `memAck` is seen. The unit makes no memory request while it is idle.
- R11: After reset the unit is idle: `busy`, `done` and `memReq` are all low. A request is taken only while `busy` is low. `done` is a one-cycle pulse that ends the operation, and `result` and `flagN` are valid during that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqOp | input | 3 | Operation code 0..6 |
| reqAddr | input | AW | Base byte address |
| reqOffset | input | 32 | Signed bit offset |
| reqLen | input | 5 | Encoded field length (0 means 32) |
| reqValue | input | 32 | Value to insert |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Operation result |
| flagN | output | 1 | Negative flag |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | Transfer is a write |
| memAddr | output | AW | Byte address of the transfer |
| memWdata | output | 8 | Write byte |
| memAck | input | 1 | Transfer accepted |
| memRdata | input | 8 | Read byte, valid with memAck |

## Verification
The checker watches the memory handshake on every cycle. It confirms that a pending request holds its address and direction, and that consecutive transfers of one phase step through ascending addresses. It also confirms that no request leaves an idle unit and that `done` is a single-cycle pulse ending the busy interval. Only the bench scenarios can show the field arithmetic. That covers the offset and length normalization, the byte count, each operation's result and flag, and the exact bytes written back. The bench checks these against a bit-by-bit memory model, which also shows that requests made while busy have no effect.

// File: rtl/bfmem_pkg.sv
package bfmem_pkg;

  localparam int FIELD_W   = 32;
  localparam int WIN_BYTES = 5;
  localparam int WIN_BITS  = WIN_BYTES * 8;
  localparam int IDX_W     = $clog2(WIN_BYTES);
  localparam int LEN_W     = $clog2(FIELD_W) + 1;

  typedef enum logic [2:0] {
    OP_EXTS = 3'd0,
    OP_EXTU = 3'd1,
    OP_INS  = 3'd2,
    OP_CHG  = 3'd3,
    OP_CLR  = 3'd4,
    OP_SET  = 3'd5,
    OP_FFO  = 3'd6
  } bfOpE;

  typedef struct packed {
    logic             load;
    logic             capRead;
    logic [IDX_W-1:0] byteIdx;
  } ctlStrobeT;

endpackage

// File: rtl/bfmem_ctrl.sv
module bfmem_ctrl
  import bfmem_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             memAck,
  input  logic [IDX_W-1:0] lastIdx,
  input  logic             isWrite,
  output ctlStrobeT        strb,
  output logic             memReq,
  output logic             memWe,
  output logic             busy,
  output logic             done
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_FIN} stateE;

  stateE            state, stateNxt;
  logic [IDX_W-1:0] idx, idxNxt;

  always_comb begin
    stateNxt     = state;
    idxNxt       = idx;
    strb.load    = 1'b0;
    strb.capRead = 1'b0;
    strb.byteIdx = idx;
    memReq       = 1'b0;
    memWe        = 1'b0;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          strb.load = 1'b1;
          idxNxt    = '0;
          stateNxt  = S_READ;
        end
      end
      S_READ: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.capRead = 1'b1;
          if (idx == lastIdx) begin
            idxNxt   = '0;
            stateNxt = isWrite ? S_WRITE : S_FIN;
          end else begin
            idxNxt = idx + 1'b1;
          end
        end
      end
      S_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          if (idx == lastIdx) stateNxt = S_FIN;
          else idxNxt = idx + 1'b1;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx   <= '0;
    end else begin
      state <= stateNxt;
      idx   <= idxNxt;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

endmodule

// File: rtl/bfmem_dpath.sv
module bfmem_dpath
  import bfmem_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobeT           strb,
  input  logic [2:0]          reqOp,
  input  logic [AW-1:0]       reqAddr,
  input  logic signed [31:0]  reqOffset,
  input  logic [4:0]          reqLen,
  input  logic [FIELD_W-1:0]  reqValue,
  input  logic [7:0]          memRdata,
  output logic [IDX_W-1:0]    lastIdx,
  output logic                isWrite,
  output logic [AW-1:0]       byteAddr,
  output logic [7:0]          wdata,
  output logic [FIELD_W-1:0]  result,
  output logic                flagN
);

  localparam int BASE_W = $clog2(WIN_BITS);

  bfOpE               opR;
  logic [AW-1:0]      addrR;
  logic [31:0]        offR;
  logic [LEN_W-1:0]   lenR;
  logic [FIELD_W-1:0] valR;
  logic [2:0]         bofsR;
  logic [IDX_W-1:0]   spanR;
  logic [WIN_BITS-1:0] win;

  logic [4:0]          lenM1;
  logic [LEN_W-1:0]    lenN;
  logic [6:0]          spanW;
  logic [BASE_W-1:0]   byteBase;
  logic [BASE_W-1:0]   fieldTop;
  logic [LEN_W-1:0]    shAmt;
  logic [FIELD_W-1:0]  fieldL, maskL, oldL, newL;
  logic [WIN_BITS-1:0] winMask, newBits, newWin;
  logic [LEN_W-1:0]    lzc;

  // request normalization
  assign lenM1 = reqLen - 5'd1;
  assign lenN  = {1'b0, lenM1} + 1'b1;
  assign spanW = {4'b0, reqOffset[2:0]} + {1'b0, lenN} - 7'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR   <= OP_EXTS;
      addrR <= '0;
      offR  <= '0;
      lenR  <= LEN_W'(FIELD_W);
      valR  <= '0;
      bofsR <= '0;
      spanR <= '0;
      win   <= '0;
    end else if (strb.load) begin
      opR   <= bfOpE'(reqOp);
      addrR <= reqAddr + AW'(reqOffset >>> 3);
      offR  <= reqOffset;
      lenR  <= lenN;
      valR  <= reqValue;
      bofsR <= reqOffset[2:0];
      spanR <= IDX_W'(spanW >> 3);
      win   <= '0;
    end else if (strb.capRead) begin
      win[byteBase +: 8] <= memRdata;
    end
  end

  // byte lane of the window addressed by the current transfer
  assign byteBase = BASE_W'(8 * (WIN_BYTES - 1)) - BASE_W'({strb.byteIdx, 3'b000});
  assign byteAddr = addrR + AW'(strb.byteIdx);
  assign lastIdx  = spanR;

  // field left-justified, old and new contents
  assign fieldTop = BASE_W'(WIN_BITS - 1) - BASE_W'(bofsR);
  assign fieldL   = win[fieldTop -: FIELD_W];
  assign maskL    = ~({FIELD_W{1'b1}} >> lenR);
  assign oldL     = fieldL & maskL;
  assign shAmt    = LEN_W'(FIELD_W) - lenR;

  always_comb begin
    case (opR)
      OP_INS:  newL = valR << shAmt;
      OP_CHG:  newL = ~oldL & maskL;
      OP_CLR:  newL = '0;
      OP_SET:  newL = maskL;
      default: newL = oldL;
    endcase
  end

  assign winMask = {maskL, 8'h00} >> bofsR;
  assign newBits = {newL, 8'h00} >> bofsR;
  assign newWin  = (win & ~winMask) | (newBits & winMask);
  assign wdata   = newWin[byteBase +: 8];
  assign isWrite = (opR == OP_INS) || (opR == OP_CHG) ||
                   (opR == OP_CLR) || (opR == OP_SET);

  // leading-zero count of the field, length when empty
  always_comb begin
    lzc = lenR;
    for (int i = 0; i < FIELD_W; i++) begin
      if (oldL[i]) lzc = LEN_W'(FIELD_W - 1 - i);
    end
  end

  always_comb begin
    case (opR)
      OP_EXTS: result = FIELD_W'($signed(oldL) >>> shAmt);
      OP_EXTU: result = oldL >> shAmt;
      OP_INS:  result = newL;
      OP_FFO:  result = offR + 32'(lzc);
      default: result = oldL;
    endcase
  end

  assign flagN = (opR == OP_INS) ? newL[FIELD_W-1] : oldL[FIELD_W-1];

endmodule

// File: rtl/bfmem_unit.sv
module bfmem_unit
  import bfmem_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [2:0]         reqOp,
  input  logic [AW-1:0]      reqAddr,
  input  logic signed [31:0] reqOffset,
  input  logic [4:0]         reqLen,
  input  logic [31:0]        reqValue,
  output logic               busy,
  output logic               done,
  output logic [31:0]        result,
  output logic               flagN,
  output logic               memReq,
  output logic               memWe,
  output logic [AW-1:0]      memAddr,
  output logic [7:0]         memWdata,
  input  logic               memAck,
  input  logic [7:0]         memRdata
);

  ctlStrobeT        strb;
  logic [IDX_W-1:0] lastIdx;
  logic             isWrite;

  bfmem_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .memAck   (memAck),
    .lastIdx  (lastIdx),
    .isWrite  (isWrite),
    .strb     (strb),
    .memReq   (memReq),
    .memWe    (memWe),
    .busy     (busy),
    .done     (done)
  );

  bfmem_dpath #(.AW(AW)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqOp     (reqOp),
    .reqAddr   (reqAddr),
    .reqOffset (reqOffset),
    .reqLen    (reqLen),
    .reqValue  (reqValue),
    .memRdata  (memRdata),
    .lastIdx   (lastIdx),
    .isWrite   (isWrite),
    .byteAddr  (memAddr),
    .wdata     (memWdata),
    .result    (result),
    .flagN     (flagN)
  );

endmodule

// File: rtl/bfmem_chk.sv
module bfmem_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          done,
  input logic          memReq,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic          memAck
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq); // R10

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=>
      (!memReq || (memWe != $past(memWe)) || (memAddr == $past(memAddr) + AW'(1)))); // R3

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> ($past(memReq) && $past(memAck) && !$past(memWe))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy)); // R11

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && !memReq)); // R11

endmodule

bind bfmem_unit bfmem_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .memReq  (memReq),
  .memWe   (memWe),
  .memAddr (memAddr),
  .memAck  (memAck)
);

// File: tb/sim_bfmem_unit.sv
`timescale 1ns/1ps
module sim_bfmem_unit;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  base;
    logic [31:0] off;
    logic [4:0]  len;
    logic [31:0] val;
    logic [7:0]  seed;
  } vecT;

  localparam int NVEC = 12;
  localparam vecT VECS [NVEC] = '{
    '{3'd0, 8'd20, 32'd3,            5'd5,  32'h0000_0000, 8'd1},
    '{3'd1, 8'd20, -32'sd13,         5'd12, 32'h0000_0000, 8'd2},
    '{3'd2, 8'd24, 32'd7,            5'd0,  32'hA5C3_0F96, 8'd3},
    '{3'd3, 8'd18, 32'd14,           5'd9,  32'h0000_0000, 8'd4},
    '{3'd4, 8'd30, -32'sd1,          5'd2,  32'h0000_0000, 8'd5},
    '{3'd5, 8'd22, 32'd0,            5'd8,  32'h0000_0000, 8'd6},
    '{3'd6, 8'd26, 32'd5,            5'd20, 32'h0000_0000, 8'd7},
    '{3'd0, 8'd28, -32'sd20,         5'd0,  32'h0000_0000, 8'd8},
    '{3'd2, 8'd16, 32'd40,           5'd1,  32'h0000_0001, 8'd9},
    '{3'd1, 8'd32, 32'd8,            5'd16, 32'h0000_0000, 8'd10},
    '{3'd6, 8'd20, -32'sd3,          5'd7,  32'h0000_0000, 8'd12},
    '{3'd3, 8'd35, 32'd31,           5'd17, 32'h0000_0000, 8'd11}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = '0;
  logic [31:0] reqAddr = '0;
  logic signed [31:0] reqOffset = '0;
  logic [4:0]  reqLen = '0;
  logic [31:0] reqValue = '0;
  logic        busy, done, flagN, memReq, memWe;
  logic [31:0] result, memAddr;
  logic [7:0]  memWdata;
  logic        memAck = 1'b0;
  logic [7:0]  memRdata = '0;

  logic [7:0]  mem [64];
  logic [7:0]  shadow [64];
  logic        tbWr = 1'b0;
  logic [5:0]  tbAddr = '0;
  logic [7:0]  tbData = '0;
  logic        clrStat = 1'b0;
  int          rdCnt = 0, wrCnt = 0, firstRd = -1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bfmem_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqOffset(reqOffset), .reqLen(reqLen),
    .reqValue(reqValue), .busy(busy), .done(done), .result(result),
    .flagN(flagN), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (tbWr) mem[tbAddr] <= tbData;
    else if (memReq && memAck && memWe) mem[memAddr[5:0]] <= memWdata;
    memAck   <= memReq && !memAck;
    memRdata <= mem[memAddr[5:0]];
    if (clrStat) begin
      rdCnt <= 0; wrCnt <= 0; firstRd <= -1;
    end else if (memReq && memAck) begin
      if (memWe) wrCnt <= wrCnt + 1;
      else begin
        if (rdCnt == 0) firstRd <= int'(memAddr);
        rdCnt <= rdCnt + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fillMem(input int seed, input bit zero);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      tbWr = 1'b1; tbAddr = 6'(i);
      tbData = zero ? 8'h00 : 8'((i * 29 + seed * 53 + 7) & 255);
      shadow[i] = tbData;
    end
    @(negedge clk);
    tbWr = 1'b0;
  endtask

  task automatic startOp(input int op, input int base, input int off, input int len5,
                         input logic [31:0] val);
    @(negedge clk); clrStat = 1'b1;
    @(negedge clk); clrStat = 1'b0;
    reqValid = 1'b1; reqOp = 3'(op); reqAddr = 32'(base);
    reqOffset = off; reqLen = 5'(len5); reqValue = val;
    @(negedge clk); reqValid = 1'b0;
  endtask

  task automatic waitDone(input string tag, output bit ok);
    ok = 0;
    for (int c = 0; c < 400; c++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
    if (!ok) check({tag, " done timeout"}, 32'd0, 32'd1);
  endtask

  // bit-by-bit reference; updates the shadow memory for writing ops
  task automatic refOp(input int op, input int base, input int off, input int len5,
                       input logic [31:0] val, output logic [31:0] res, output logic n,
                       output int span, output int first);
    int L, a, ff;
    logic [31:0] u;
    logic fb [32];
    logic nb;
    L = ((len5 - 1) & 31) + 1;
    u = '0; ff = -1;
    for (int k = 0; k < L; k++) begin
      a = base * 8 + off + k;
      fb[k] = shadow[a >>> 3][7 - (a & 7)];
      u = {u[30:0], fb[k]};
      if (ff < 0 && fb[k]) ff = k;
    end
    n = fb[0];
    res = '0;
    case (op)
      0: begin res = u; if (fb[0] && L < 32) res = u | (32'hFFFF_FFFF << L); end
      1: res = u;
      2: begin res = val << (32 - L); n = val[L-1]; end
      3, 4, 5: res = u << (32 - L);
      default: res = 32'(off + ((ff < 0) ? L : ff));
    endcase
    if (op >= 2 && op <= 5) begin
      for (int k = 0; k < L; k++) begin
        a = base * 8 + off + k;
        case (op)
          2: nb = val[L-1-k];
          3: nb = ~fb[k];
          4: nb = 1'b0;
          default: nb = 1'b1;
        endcase
        shadow[a >>> 3][7 - (a & 7)] = nb;
      end
    end
    span  = (((off & 7) + L - 1) >> 3) + 1;
    first = base + (off >>> 3);
  endtask

  function automatic string opTag(input int op);
    case (op)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3, 4, 5: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int memDiff();
    int d = 0;
    for (int i = 0; i < 64; i++) if (mem[i] !== shadow[i]) d++;
    return d;
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] eRes;
    logic eN;
    int eSpan, eFirst, op;
    bit ok;
    string tg;

    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset busy", 32'(busy), 32'd0);
    check("R11 reset done", 32'(done), 32'd0);
    check("R11 reset memReq", 32'(memReq), 32'd0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", 32'({busy, done, memReq}), 32'd0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      op = int'(VECS[i].op);
      fillMem(int'(VECS[i].seed), 1'b0);
      refOp(op, int'(VECS[i].base), int'($signed(VECS[i].off)), int'(VECS[i].len),
            VECS[i].val, eRes, eN, eSpan, eFirst);
      startOp(op, int'(VECS[i].base), int'($signed(VECS[i].off)), int'(VECS[i].len), VECS[i].val);
      tg = $sformatf("vec%0d %s", i, opTag(op));
      waitDone(tg, ok);
      if (ok) begin
        check({tg, " result"}, result, eRes);
        check({tg, " flagN"}, 32'(flagN), 32'(eN));
        check({tg, " R3 read count"}, 32'(rdCnt), 32'(eSpan));
        check({tg, " R2 first address"}, 32'(firstRd), 32'(eFirst));
        check({tg, " R9 write count"}, 32'(wrCnt), (op >= 2 && op <= 5) ? 32'(eSpan) : 32'd0);
        check({tg, " R9 memory bytes differing"}, 32'(memDiff()), 32'd0);
      end
      @(negedge clk);
      check({tg, " R11 done single pulse"}, 32'({done, busy}), 32'd0);
    end

    // R1: encoded length 0 covers 32 bits
    fillMem(21, 1'b0);
    startOp(1, 20, 0, 0, 32'd0);
    waitDone("R1 len0", ok);
    if (ok) check("R1 len0 unsigned extract", result,
                  {shadow[20], shadow[21], shadow[22], shadow[23]});

    // R2: offset -1 is bit 0 (lsb) of the preceding byte
    startOp(1, 21, -1, 1, 32'd0);
    waitDone("R2 neg offset", ok);
    if (ok) check("R2 offset -1 selects lsb of base-1", result, 32'(shadow[20][0]));

    // R4 R5 hard values: byte 0xB1 at 20, top nibble 1011
    @(negedge clk); tbWr = 1'b1; tbAddr = 6'd20; tbData = 8'hB1; shadow[20] = 8'hB1;
    @(negedge clk); tbWr = 1'b0;
    startOp(1, 20, 0, 4, 32'd0);
    waitDone("R5 nibble", ok);
    if (ok) begin
      check("R5 unsigned nibble", result, 32'h0000_000B);
      check("R5 flagN", 32'(flagN), 32'd1);
    end
    startOp(0, 20, 0, 4, 32'd0);
    waitDone("R4 nibble", ok);
    if (ok) check("R4 signed nibble", result, 32'hFFFF_FFFB);

    // R8: all-zero field gives offset + length
    fillMem(0, 1'b1);
    startOp(6, 20, 9, 6, 32'd0);
    waitDone("R8 zero", ok);
    if (ok) begin
      check("R8 zero field offset+len", result, 32'd15);
      check("R8 zero field flagN", 32'(flagN), 32'd0);
    end
    startOp(6, 20, -2, 0, 32'd0);
    waitDone("R8 zero len32", ok);
    if (ok) check("R8 zero field len 32", result, 32'd30);

    // R11: request while busy is ignored (would set byte 0 if taken)
    fillMem(0, 1'b1);
    refOp(1, 24, 3, 10, 32'd0, eRes, eN, eSpan, eFirst);
    startOp(1, 24, 3, 10, 32'd0);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 3'd5; reqAddr = 32'd0; reqOffset = 0; reqLen = 5'd8;
    @(negedge clk); reqValid = 1'b0;
    waitDone("R11 busy", ok);
    if (ok) check("R11 busy op result", result, eRes);
    begin
      int extra = 0;
      @(negedge clk);
      for (int c = 0; c < 30; c++) begin
        if (done) extra++;
        @(negedge clk);
      end
      check("R11 no second done", 32'(extra), 32'd0);
      check("R11 byte 0 untouched", 32'(mem[0]), 32'd0);
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule